// File: doc/BRIEF.md
# Backdoor Key Security Gate

This block holds the security state of a device. While reset is held it takes a copy of a stored options byte into a live options register. The live value is fixed until the next reset. From that register it decodes four things: a key-enable flag, a flag that turns off vector redirection, a program-mode flag and a two-bit security code. The stored options byte and the stored eight-byte key reach the block on input ports. Erasing and reprogramming that storage are handled elsewhere.

While the device is secured and the key-enable flag is set, firmware can unlock it by writing eight key bytes, one write per accepted byte. Each byte is compared with the stored key byte at the current position, starting at position 0. When all eight match in order, the device reads as unsecured until the next reset. A wrong byte ends the attempt and blocks any further attempt until reset. Writes marked as coming from the debug port are never counted.

Top module: `secure_gate`

## Requirements
- R1: While `rst` is high on a clock edge, the live options register loads `nv_opt_i` with bits 4:2 forced to 0, and `opt_o` shows that value. While `rst` is low, `opt_o` holds still whatever `nv_opt_i` does.
- R2: The live options fields are decoded as follows. `key_en_o` is bit 7, `redirect_off_o` is bit 6, `prog_mode_o` is bit 5 and `sec_code_o` is bits 1:0.
- R3: After reset, `secured_o` is 1 for every security code except 2'b10, which reads as unsecured.
- R4: Some writes are accepted. Key byte k is `nv_key_i[8k+7:8k]`. When eight accepted writes in a row carry key bytes 0 to 7 in that order, `secured_o` falls on the clock edge that takes the eighth write. It stays 0 until reset, and `opt_o` is not changed by this.
- R5: A write with `wr_dbg_i`=1 neither advances the key position nor aborts the attempt. Debug writes alone never unlock.
- R6: When the key-enable bit is 0, no sequence of writes changes `secured_o`.
- R7: An accepted write whose byte differs from the expected key byte aborts the attempt. Until the next reset, no later write can unlock, and that includes a complete correct key.
- R8: Writes made while `secured_o` is 0 are ignored. `secured_o` stays 0 and `opt_o` is unchanged.
- R9: A reset clears both an unlock and a partial attempt. After reset the device is secured again, and a fresh full key from position 0 is needed to unlock it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; options are loaded while high |
| nv_opt_i | input | 8 | Stored options byte |
| nv_key_i | input | 64 | Stored key, byte k in bits 8k+7:8k |
| wr_valid_i | input | 1 | One key-byte write this cycle |
| wr_dbg_i | input | 1 | The write comes from the debug port |
| wr_data_i | input | 8 | Key byte being written |
| opt_o | output | 8 | Live options register |
| key_en_o | output | 1 | Key unlock permitted |
| redirect_off_o | output | 1 | Vector redirection disabled |
| prog_mode_o | output | 1 | Program-mode flag |
| sec_code_o | output | 2 | Security code |
| secured_o | output | 1 | Device currently secured |

## Verification
The assertions take two things for granted. First, `nv_key_i` stays stable while an attempt is under way. Second, the options register is only loaded through reset, so every clock before the first reset is outside their scope. The bench therefore changes the key and the options byte only while `rst` is high, with one exception. That exception is the deliberate check that `nv_opt_i` is ignored outside reset, and it leaves the key untouched. The bench drives every write for exactly one cycle, between clock edges, so no two writes merge.

// File: rtl/secure_pkg.sv
package secure_pkg;

    localparam int BYTE_W    = 8;
    localparam int KEY_BYTES = 8;

    // Live options byte layout; reserved bits always read as zero.
    typedef struct packed {
        logic       key_en;
        logic       redirect_off;
        logic       prog_mode;
        logic [2:0] rsvd;
        logic [1:0] sec_code;
    } opt_t;

    localparam logic [1:0] CODE_OPEN = 2'b10;

    function automatic opt_t clean_opt(input logic [7:0] raw);
        opt_t o;
        o      = opt_t'(raw);
        o.rsvd = 3'b000;
        return o;
    endfunction

    function automatic logic code_secured(input logic [1:0] code);
        return code != CODE_OPEN;
    endfunction

endpackage

// File: rtl/opt_capture.sv
module opt_capture
    import secure_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] nv_opt_i,
    output opt_t       opt_o
);

    opt_t opt_q;

    always_ff @(posedge clk) begin
        if (rst) opt_q <= clean_opt(nv_opt_i);
    end

    assign opt_o = opt_q;

    // R1: outside reset the live register never moves
    assert_opt_hold_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(opt_q));

endmodule

// File: rtl/key_seq_match.sv
module key_seq_match #(
    parameter int BYTE_W    = 8,
    parameter int KEY_BYTES = 8,
    localparam int IDX_W    = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1,
    localparam int KEY_W    = BYTE_W * KEY_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic              wr_valid_i,
    input  logic              wr_dbg_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [KEY_W-1:0]  key_i,
    output logic              unlocked_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_BYTES - 1);

    logic [IDX_W-1:0]  idx_q;
    logic              blocked_q;
    logic              unlocked_q;
    logic              take;
    logic              hit;
    logic [BYTE_W-1:0] expect_byte;

    assign expect_byte = key_i[idx_q*BYTE_W +: BYTE_W];
    assign take        = wr_valid_i && !wr_dbg_i && arm_i && !blocked_q && !unlocked_q;
    assign hit         = (wr_data_i == expect_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            blocked_q  <= 1'b0;
            unlocked_q <= 1'b0;
        end else if (take) begin
            if (!hit) begin
                blocked_q <= 1'b1;
                idx_q     <= '0;
            end else if (idx_q == LAST_IDX) begin
                unlocked_q <= 1'b1;
                idx_q      <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign unlocked_o = unlocked_q;

    // R5: debug writes leave the attempt untouched
    assert_dbg_inert_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_i && wr_dbg_i) |=> ($stable(idx_q) && $stable(blocked_q) && $stable(unlocked_q)));

    // R7: a blocked attempt never turns into an unlock
    assert_block_holds_R7: assert property (@(posedge clk) disable iff (rst)
        blocked_q |=> (blocked_q && !$rose(unlocked_q)));

    // R4: once open, stays open until reset
    assert_unlock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        unlocked_q |=> unlocked_q);

    // R8: after unlock, writes no longer move the position
    assert_open_ignores_R8: assert property (@(posedge clk) disable iff (rst)
        unlocked_q |=> $stable(idx_q));

endmodule

// File: rtl/secure_gate.sv
module secure_gate
    import secure_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [7:0]                    nv_opt_i,
    input  logic [BYTE_W*KEY_BYTES-1:0]   nv_key_i,
    input  logic                          wr_valid_i,
    input  logic                          wr_dbg_i,
    input  logic [BYTE_W-1:0]             wr_data_i,
    output logic [7:0]                    opt_o,
    output logic                          key_en_o,
    output logic                          redirect_off_o,
    output logic                          prog_mode_o,
    output logic [1:0]                    sec_code_o,
    output logic                          secured_o
);

    opt_t opt;
    logic unlocked;
    logic code_sec;

    opt_capture u_opt (
        .clk      (clk),
        .rst      (rst),
        .nv_opt_i (nv_opt_i),
        .opt_o    (opt)
    );

    assign code_sec = code_secured(opt.sec_code);

    key_seq_match #(
        .BYTE_W    (BYTE_W),
        .KEY_BYTES (KEY_BYTES)
    ) u_match (
        .clk        (clk),
        .rst        (rst),
        .arm_i      (opt.key_en && code_sec),
        .wr_valid_i (wr_valid_i),
        .wr_dbg_i   (wr_dbg_i),
        .wr_data_i  (wr_data_i),
        .key_i      (nv_key_i),
        .unlocked_o (unlocked)
    );

    assign opt_o          = opt;
    assign key_en_o       = opt.key_en;
    assign redirect_off_o = opt.redirect_off;
    assign prog_mode_o    = opt.prog_mode;
    assign sec_code_o     = opt.sec_code;
    assign secured_o      = code_sec && !unlocked;

    // R6: no unlock can exist while key use is disabled
    assert_keyen_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !key_en_o |-> !unlocked);

    // R4: an unlock never rewrites the options register
    assert_unlock_keeps_opt_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $stable(opt_o));

endmodule

// File: tb/sim_secure_gate.sv
module sim_secure_gate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  nv_opt = 8'h00;
    logic [63:0] nv_key = 64'h0;
    logic        wr_valid = 1'b0;
    logic        wr_dbg = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  opt_o;
    logic        key_en_o, redirect_off_o, prog_mode_o, secured_o;
    logic [1:0]  sec_code_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secure_gate u0 (
        .clk(clk), .rst(rst), .nv_opt_i(nv_opt), .nv_key_i(nv_key),
        .wr_valid_i(wr_valid), .wr_dbg_i(wr_dbg), .wr_data_i(wr_data),
        .opt_o(opt_o), .key_en_o(key_en_o), .redirect_off_o(redirect_off_o),
        .prog_mode_o(prog_mode_o), .sec_code_o(sec_code_o), .secured_o(secured_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] kb(input logic [63:0] k, input int i);
        return k[i*8 +: 8];
    endfunction

    function automatic logic [63:0] make_key(input int seed);
        logic [63:0] k;
        for (int i = 0; i < 8; i++) k[i*8 +: 8] = 8'((seed * 37 + i * 53 + 11) & 8'hFF);
        return k;
    endfunction

    task automatic do_reset(input logic [7:0] opt, input logic [63:0] key);
        @(negedge clk);
        rst = 1'b1; nv_opt = opt; nv_key = key;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d, input logic dbg);
        @(negedge clk);
        wr_valid = 1'b1; wr_dbg = dbg; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0; wr_dbg = 1'b0;
    endtask

    task automatic send_key(input logic [63:0] k, input logic dbg);
        for (int i = 0; i < 8; i++) wr(kb(k, i), dbg);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] key;
        logic [7:0]  o;
        // R1 R2 R3: exhaustive options sweep
        for (int v = 0; v < 256; v++) begin
            do_reset(8'(v), 64'h0);
            check("R1 opt", opt_o, 8'(v) & 8'hE3);
            check("R2 key_en", {7'b0, key_en_o}, {7'b0, v[7]});
            check("R2 redirect", {7'b0, redirect_off_o}, {7'b0, v[6]});
            check("R2 prog", {7'b0, prog_mode_o}, {7'b0, v[5]});
            check("R2 code", {6'b0, sec_code_o}, {6'b0, v[1:0]});
            check("R3 secured", {7'b0, secured_o}, {7'b0, v[1:0] != 2'b10});
        end

        // R1: options input ignored outside reset
        do_reset(8'h81, 64'h0);
        @(negedge clk); nv_opt = 8'h5E;
        repeat (3) @(negedge clk);
        check("R1 hold", opt_o, 8'h81);

        // R4 R5: correct key with debug writes mixed in, several keys and codes
        for (int s = 0; s < 3; s++) begin
            key = make_key(s + 1);
            o = 8'h80 | 8'(s == 2 ? 3 : s) | 8'h40;
            do_reset(o, key);
            for (int i = 0; i < 8; i++) begin
                wr(kb(key, i) ^ 8'h5A, 1'b1);
                wr(kb(key, i), 1'b0);
                check("R4 progress", {7'b0, secured_o}, {7'b0, i != 7});
            end
            check("R4 opt kept", opt_o, o & 8'hE3);
            wr(8'h00, 1'b0); wr(kb(key, 0) ^ 8'hFF, 1'b0);
            check("R8 stays open", {7'b0, secured_o}, 8'h00);
            check("R8 opt kept", opt_o, o & 8'hE3);
            do_reset(o, key);
            check("R9 re-secured", {7'b0, secured_o}, 8'h01);
        end

        // R7: mismatch at every position blocks a later full correct key
        key = make_key(7);
        for (int p = 0; p < 8; p++) begin
            do_reset(8'h80, key);
            for (int i = 0; i < p; i++) wr(kb(key, i), 1'b0);
            wr(kb(key, p) ^ 8'h01, 1'b0);
            send_key(key, 1'b0);
            check("R7 blocked", {7'b0, secured_o}, 8'h01);
        end
        // R7: reversed order is a mismatch
        do_reset(8'h80, key);
        for (int i = 7; i >= 0; i--) wr(kb(key, i), 1'b0);
        send_key(key, 1'b0);
        check("R7 reversed", {7'b0, secured_o}, 8'h01);

        // R6: key disabled, codes 00 01 11
        for (int c = 0; c < 4; c++) begin
            if (c == 2) continue;
            do_reset(8'(c), key);
            send_key(key, 1'b0);
            check("R6 no unlock", {7'b0, secured_o}, 8'h01);
        end

        // R5: debug-only key never unlocks and does not block firmware
        do_reset(8'h80, key);
        send_key(key, 1'b1);
        check("R5 dbg only", {7'b0, secured_o}, 8'h01);
        wr(8'hEE ^ kb(key, 0), 1'b1);
        send_key(key, 1'b0);
        check("R5 fw after dbg", {7'b0, secured_o}, 8'h00);

        // R8: code 10 with writes ignored
        do_reset(8'hA2, key);
        wr(8'h12, 1'b0); send_key(key, 1'b0);
        check("R8 open code", {7'b0, secured_o}, 8'h00);
        check("R8 open opt", opt_o, 8'hA2);

        // R9: partial attempt cleared by reset
        do_reset(8'h80, key);
        for (int i = 0; i < 4; i++) wr(kb(key, i), 1'b0);
        do_reset(8'h80, key);
        for (int i = 4; i < 8; i++) wr(kb(key, i), 1'b0);
        check("R9 partial lost", {7'b0, secured_o}, 8'h01);
        do_reset(8'h80, key);
        send_key(key, 1'b0);
        check("R9 fresh key", {7'b0, secured_o}, 8'h00);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule